// File: doc/BRIEF.md
# Systolic Convolution Stage with Pair-Swap Diffusion

This block scrambles an 8-bit grayscale pixel stream in a single pass. Pixels arrive row-major in groups of nine that form one 3×3 tile. Every pixel moves through a short chain of three processing elements that hold the tile's filter weights. Those weights come from a chaotic sequence generator, and the block captures them once at the start of each tile. Each element multiplies the pixel it holds by its weight and adds the running sum from the element before it. The pixel then shifts on to the next element with the following accepted pixel. The sum at the end of the chain is the confusion term for the newest pixel.

Diffusion happens where the results are written. Before a result reaches its accumulator, the block moves it to a different position in the tile: the two columns of each column pair trade places. A bank of nine accumulators, one for each tile position, adds the new term to what that position already holds from earlier tiles. The block emits the updated value together with the position it was written to. The output therefore depends on every earlier tile, and it appears in permuted locations, with no image-sized buffer.

A two-state controller tracks the tiles. In ST_WAIT it expects the first pixel of a tile. The transition WAIT→BODY fires when a pixel is accepted; it captures the weights and clears the older taps of the chain. In ST_BODY the controller counts pixels. The transition BODY→WAIT fires when the ninth pixel of the tile is accepted.

Top module: `sc_systolic_diffuser`

## Requirements
- R1: Reset clears out_valid to 0 and all nine accumulators to 0. After reset, the first valid pixel is tile position 0, and the first output at each position is the bare filter term.
- R2: Tile positions count accepted pixels (cycles with in_valid high) from 0 to 8, in row-major order (row = index/3, column = index mod 3), and then wrap to 0. Cycles with in_valid low do not advance the count.
- R3: The weights are taken from chaos_xyz only in the cycle that accepts tile position 0. The field layout is x = [23:16], y = [15:8], z = [7:0]. A change on chaos_xyz at any other time has no effect on the outputs of that tile.
- R4: The filter term for the pixel at tile position j is (y·p[j] + z·p[j−1] + x·p[j−2]) mod 256, where p[j−1] and p[j−2] are the previous accepted pixels of the same tile.
- R5: Taps that would reach before position 0 of the current tile contribute zero. Pixels of the previous tile never enter the filter term.
- R6: Each result adds the filter term to the accumulator of its destination position modulo 256, stores the sum back there, and outputs the sum on out_pix.
- R7: The destination position keeps the row and swaps the column: columns 0 and 1 trade places and column 2 stays. out_pos carries the destination index (row·3 + column) and is always below 9.
- R8: out_valid goes high exactly two clock cycles after each accepted pixel and at no other time. Results leave in the order the pixels arrived, whatever the gaps in in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when in_pix holds a pixel to accept |
| in_pix | input | 8 | Grayscale pixel, row-major within the tile |
| chaos_xyz | input | 24 | Chaotic generator sample {x, y, z} |
| out_valid | output | 1 | High when out_pix and out_pos hold a result |
| out_pix | output | 8 | Updated accumulator value (ciphertext pixel) |
| out_pos | output | 4 | Destination tile position of the result |

## Verification
The hardest case to reach from the ports is the tile boundary while the stream has irregular gaps. Here the chain still holds pixels from the previous tile, and these must not enter the first two terms of the new tile. The weights also have to change at exactly the accepted first pixel, not at the first cycle with a new chaos value. The stimulus ends one tile with saturated pixels of value 255 and starts the next tile after random idle gaps. It changes chaos_xyz on every cycle, idle cycles included, so a wrong capture point or a stale tap shows up as a wrong ciphertext value at a known position. A reset that cuts a tile short then checks that the accumulators and the position counter start clean.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_BODY = 1'b1
    } tile_state_e;

    // Destination index after the column-pair exchange; a column with
    // no partner keeps its place.
    function automatic int unsigned swap_dest(int unsigned pos, int unsigned tile);
        int unsigned row;
        int unsigned col;
        row = pos / tile;
        col = pos % tile;
        if ((col | 1) < tile) begin
            col = col ^ 1;
        end
        return row * tile + col;
    endfunction

endpackage

// File: rtl/sc_tile_ctrl.sv
`timescale 1ns/1ps
module sc_tile_ctrl #(
    parameter int PIX_W = 8,
    parameter int TILE  = 3,
    parameter int NTAP  = 3,
    parameter int POS_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [3*PIX_W-1:0]          chaos_xyz,
    output logic                        tile_first,
    output logic                        ld_valid,
    output logic [POS_W-1:0]            ld_pos,
    output logic [NTAP-1:0][PIX_W-1:0]  w_taps
);
    import sc_pkg::*;

    localparam int NPOS = TILE * TILE;

    tile_state_e        state_q;
    tile_state_e        state_d;
    logic [POS_W-1:0]   idx_q;
    logic               last_pix;

    assign last_pix   = (idx_q == POS_W'(NPOS - 1));
    assign tile_first = (state_q == ST_WAIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (in_valid) begin
                    state_d = ST_BODY;
                end
            end
            ST_BODY: begin
                if (in_valid && last_pix) begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // outputs: position counter, load strobe, weight latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            ld_valid <= 1'b0;
            ld_pos   <= '0;
            w_taps   <= '0;
        end else begin
            ld_valid <= in_valid;
            if (in_valid) begin
                ld_pos <= idx_q;
                idx_q  <= last_pix ? '0 : idx_q + 1'b1;
                if (tile_first) begin
                    // tap order: y on the newest pixel, then z, then x
                    w_taps[0] <= chaos_xyz[2*PIX_W-1:PIX_W];
                    w_taps[1] <= chaos_xyz[PIX_W-1:0];
                    w_taps[2] <= chaos_xyz[3*PIX_W-1:2*PIX_W];
                end
            end
        end
    end

endmodule

// File: rtl/sc_pe.sv
`timescale 1ns/1ps
module sc_pe #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             zero_ld,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [PIX_W-1:0] weight,
    input  logic [PIX_W-1:0] psum_in,
    output logic [PIX_W-1:0] pix_q,
    output logic [PIX_W-1:0] psum_out
);
    localparam int PROD_W = 2 * PIX_W;

    logic [PROD_W-1:0] prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (shift_en) begin
            pix_q <= zero_ld ? '0 : pix_in;
        end
    end

    assign prod     = {{PIX_W{1'b0}}, weight} * {{PIX_W{1'b0}}, pix_q};
    assign psum_out = psum_in + prod[PIX_W-1:0];

endmodule

// File: rtl/sc_acc_bank.sv
`timescale 1ns/1ps
module sc_acc_bank #(
    parameter int PIX_W = 8,
    parameter int TILE  = 3,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [POS_W-1:0] ld_pos,
    input  logic [PIX_W-1:0] sum,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic [POS_W-1:0] out_pos
);
    localparam int NPOS = TILE * TILE;

    logic [PIX_W-1:0] acc_q [NPOS];
    logic [POS_W-1:0] dest;
    logic [PIX_W-1:0] new_val;

    assign dest    = POS_W'(sc_pkg::swap_dest(32'(ld_pos), TILE));
    assign new_val = acc_q[dest] + sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NPOS; g++) begin
                acc_q[g] <= '0;
            end
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_pos   <= '0;
        end else begin
            out_valid <= ld_valid;
            if (ld_valid) begin
                for (int g = 0; g < NPOS; g++) begin
                    if (dest == POS_W'(g)) begin
                        acc_q[g] <= new_val;
                    end
                end
                out_pix <= new_val;
                out_pos <= dest;
            end
        end
    end

endmodule

// File: rtl/sc_systolic_diffuser.sv
`timescale 1ns/1ps
module sc_systolic_diffuser #(
    parameter int PIX_W = 8,
    parameter int TILE  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [PIX_W-1:0]            in_pix,
    input  logic [3*PIX_W-1:0]          chaos_xyz,
    output logic                        out_valid,
    output logic [PIX_W-1:0]            out_pix,
    output logic [$clog2(TILE*TILE)-1:0] out_pos
);
    localparam int NTAP  = 3;
    localparam int NPOS  = TILE * TILE;
    localparam int POS_W = $clog2(NPOS);

    logic                        tile_first;
    logic                        ld_valid;
    logic [POS_W-1:0]            ld_pos;
    logic [NTAP-1:0][PIX_W-1:0]  w_taps;
    logic [NTAP-1:0][PIX_W-1:0]  pe_pix;
    logic [NTAP:0][PIX_W-1:0]    psum;

    sc_tile_ctrl #(
        .PIX_W(PIX_W), .TILE(TILE), .NTAP(NTAP), .POS_W(POS_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .chaos_xyz  (chaos_xyz),
        .tile_first (tile_first),
        .ld_valid   (ld_valid),
        .ld_pos     (ld_pos),
        .w_taps     (w_taps)
    );

    assign psum[0] = '0;

    for (genvar k = 0; k < NTAP; k++) begin : g_pe
        if (k == 0) begin : g_head
            sc_pe #(.PIX_W(PIX_W)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (in_valid),
                .zero_ld  (1'b0),
                .pix_in   (in_pix),
                .weight   (w_taps[k]),
                .psum_in  (psum[k]),
                .pix_q    (pe_pix[k]),
                .psum_out (psum[k+1])
            );
        end else begin : g_body
            sc_pe #(.PIX_W(PIX_W)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (in_valid),
                .zero_ld  (tile_first),
                .pix_in   (pe_pix[k-1]),
                .weight   (w_taps[k]),
                .psum_in  (psum[k]),
                .pix_q    (pe_pix[k]),
                .psum_out (psum[k+1])
            );
        end
    end

    sc_acc_bank #(
        .PIX_W(PIX_W), .TILE(TILE), .POS_W(POS_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_pos    (ld_pos),
        .sum       (psum[NTAP]),
        .out_valid (out_valid),
        .out_pix   (out_pix),
        .out_pos   (out_pos)
    );

endmodule

// File: rtl/sc_systolic_diffuser_chk.sv
`timescale 1ns/1ps
module sc_systolic_diffuser_chk #(
    parameter int PIX_W = 8,
    parameter int TILE  = 3,
    parameter int NTAP  = 3,
    parameter int POS_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        out_valid,
    input logic [POS_W-1:0]            out_pos,
    input logic                        tile_first,
    input logic [NTAP-1:0][PIX_W-1:0]  pe_pix,
    input logic [NTAP-1:0][PIX_W-1:0]  w_taps
);
    localparam int NPOS = TILE * TILE;

    logic [POS_W-1:0] out_cnt;
    int               exp_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_cnt <= '0;
        end else if (out_valid) begin
            out_cnt <= (out_cnt == POS_W'(NPOS - 1)) ? '0 : out_cnt + 1'b1;
        end
    end

    always_comb begin
        int c;
        int ec;
        c = int'(out_cnt) % TILE;
        if (c % 2 == 1)        ec = c - 1;
        else if (c + 1 < TILE) ec = c + 1;
        else                   ec = c;
        exp_pos = int'(out_cnt) - c + ec;
    end

    AST_LAT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                  // R8
    AST_LAT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));                            // R8
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_pos) < NPOS));                        // R7
    AST_POS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_pos) == exp_pos));                    // R2
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tile_first) |=> (pe_pix[NTAP-1:1] == '0));       // R5
    AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && tile_first) |=> $stable(w_taps));               // R3

endmodule

bind sc_systolic_diffuser sc_systolic_diffuser_chk #(
    .PIX_W(PIX_W), .TILE(TILE), .NTAP(NTAP), .POS_W(POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_pos    (out_pos),
    .tile_first (tile_first),
    .pe_pix     (pe_pix),
    .w_taps     (w_taps)
);

// File: tb/sc_systolic_diffuser_tb.sv
`timescale 1ns/1ps
module sc_systolic_diffuser_tb;
    localparam int NPOS = 9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_pix;
    logic [23:0] chaos_xyz;
    logic        out_valid;
    logic [7:0]  out_pix;
    logic [3:0]  out_pos;

    always #2.5 clk = ~clk;

    sc_systolic_diffuser u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .chaos_xyz(chaos_xyz), .out_valid(out_valid), .out_pix(out_pix),
        .out_pos(out_pos)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    longint cyc      = 0;

    int     q_pos[$];
    int     q_pix[$];
    longint q_cyc[$];
    string  q_tag[$];

    int m_idx;
    int m_w[3];
    int m_h[3];
    int m_acc[NPOS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_idx = 0;
        for (int i = 0; i < 3; i++) begin m_h[i] = 0; m_w[i] = 0; end
        for (int i = 0; i < NPOS; i++) m_acc[i] = 0;
    endtask

    // driver: apply one pixel and push the golden result
    task automatic send(input int pix, input int chaos, input string tag);
        int s, col, dcol, dest;
        @(negedge clk);
        in_valid  = 1'b1;
        in_pix    = pix[7:0];
        chaos_xyz = chaos[23:0];
        if (m_idx == 0) begin
            m_w[0] = (chaos >> 8) & 255;   // y
            m_w[1] = chaos & 255;          // z
            m_w[2] = (chaos >> 16) & 255;  // x
            m_h[1] = 0;
            m_h[2] = 0;
        end else begin
            m_h[2] = m_h[1];
            m_h[1] = m_h[0];
        end
        m_h[0] = pix & 255;
        s    = (m_w[0] * m_h[0] + m_w[1] * m_h[1] + m_w[2] * m_h[2]) & 255;
        col  = m_idx % 3;
        dcol = (col == 0) ? 1 : ((col == 1) ? 0 : 2);
        dest = (m_idx / 3) * 3 + dcol;
        m_acc[dest] = (m_acc[dest] + s) & 255;
        q_pos.push_back(dest);
        q_pix.push_back(m_acc[dest]);
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
        m_idx = (m_idx + 1) % NPOS;
    endtask

    // idle cycles with junk on the data inputs
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_pix    = 8'($urandom);
            chaos_xyz = 24'($urandom);
        end
    endtask

    task automatic send_tile(input int fixed_chaos, input bit vary_chaos,
                             input int fixed_pix, input int gap_max, input string tag);
        for (int i = 0; i < NPOS; i++) begin
            int pix, ch;
            pix = (fixed_pix >= 0) ? fixed_pix : int'($urandom % 256);
            ch  = vary_chaos ? int'($urandom % 24'hFFFFFF) : fixed_chaos;
            send(pix, ch, tag);
            if (gap_max > 0) idle(int'($urandom % (gap_max + 1)));
        end
        idle(1);
    endtask

    // monitor: compare each result with the scoreboard head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (q_pix.size() == 0) begin
                chk(1'b0, "R8", "unexpected out_valid", 1, 0);
            end else begin
                int     ep, ex;
                longint ec;
                string  tg;
                ep = q_pos.pop_front();
                ex = q_pix.pop_front();
                ec = q_cyc.pop_front();
                tg = q_tag.pop_front();
                chk(int'(out_pos) == ep, tg, "R7 destination position", out_pos, ep);
                chk(int'(out_pix) == ex, tg, "R4 R6 ciphertext value", out_pix, ex);
                chk(cyc == ec, tg, "R8 output cycle", cyc, ec);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; chaos_xyz = '0;
        model_reset();
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        end

        // R1 R4: first tile, accumulators start at zero
        send_tile(24'h030201, 1'b0, -1, 0, "R1 R4");
        // R3: chaos changes every pixel, only the first sample counts
        send_tile(0, 1'b1, -1, 0, "R3 R6");
        // R5: saturated tile then a gapped tile across the boundary
        send_tile(24'h7F55A3, 1'b0, 255, 0, "R5");
        send_tile(24'h11FE09, 1'b0, -1, 3, "R5 R8");
        // R2 R6 R7: long stream with random gaps, varying weights
        for (int t = 0; t < 20; t++) begin
            send_tile(int'($urandom % 24'hFFFFFF), t[0], -1, (t % 3), "R2 R6 R7");
        end
        // R1 R2: partial tile cut by reset, then a clean tile
        for (int i = 0; i < 5; i++) send(int'($urandom % 256), 24'h123456, "R2");
        idle(5);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after mid reset", out_valid, 0);
        send_tile(24'hC0FFEE, 1'b0, -1, 1, "R1 R2");
        idle(6);
        chk(q_pix.size() == 0, "R8", "results still outstanding", q_pix.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule